// File: doc/BRIEF.md
# Timer-Driven Divider and Buzzer Pad Output

This block drives three alternate-function output pads. A reloading up-counter runs from the block clock. Every time it wraps past its all-ones value, it reloads a software-supplied start value N and toggles a divider flip-flop. The divider pad therefore carries a square wave whose full period is 2 x (2^CNT_W - N) clocks. A second pair of pads carries a buzzer tone taken from an external tone input, either as a complementary pair or as a single line.

Three port data bits sit beside the pads and act as mode selects. One data bit gates the divider pad. Two data bits choose the buzzer pattern. A data bit of 1 always forces its pad low. The pads are push-pull outputs, and a build parameter decides whether they are registered or driven straight from the selection logic.

Top module: `tone_div_out`

## Requirements
- R1: While `run` is low the counter loads `preload` on every clock; while `run` is high it advances by one per clock, so the first divider toggle comes 2^CNT_W - N clocks after `run` rises.
- R2: On the clock where `run` is high and the counter is all ones, the counter loads the `preload` value present in that cycle. A `preload` change during a count only alters the periods that start after the next wrap.
- R3: Each wrap toggles the divider state, so with `dat_div` = 0 the half period on `pad_div` is 2^CNT_W - N clocks.
- R4: When `dat_div` is 1, `pad_div` is 0 whatever the counter does.
- R5: When `dat_div` is 0 and `run` is low, `pad_div` holds the last divider state.
- R6: With `dat_bz_a` = 0 and `dat_bz_b` = 0, `pad_bz_a` follows `tone` and `pad_bz_b` is its complement.
- R7: With `dat_bz_a` = 0 and `dat_bz_b` = 1, `pad_bz_a` follows `tone` and `pad_bz_b` is 0.
- R8: With `dat_bz_a` = 1, both buzzer pads are 0 regardless of `dat_bz_b` and `tone`.
- R9: With REG_PADS = 1, each pad changes one clock after its selecting inputs. With REG_PADS = 0, it changes in the same cycle.
- R10: Reset (`rst_n` low) clears the divider state and the pad registers, so `pad_div` reads 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Counter run enable |
| preload | input | CNT_W | Reload value N |
| tone | input | 1 | Buzzer tone source |
| dat_bz_a | input | 1 | Data bit of the first buzzer pad |
| dat_bz_b | input | 1 | Data bit of the second buzzer pad |
| dat_div | input | 1 | Data bit of the divider pad |
| pad_bz_a | output | 1 | First buzzer pad |
| pad_bz_b | output | 1 | Second buzzer pad |
| pad_div | output | 1 | Divider pad |

## Verification
The bench builds the block with CNT_W = 8 and REG_PADS = 1. The 8-bit counter keeps the longest half period, with N = 0, at 256 clocks, so the wrap at both extremes of N can be measured directly. N = 255 gives a toggle on every clock. The registered pad variant adds one clock to the start-up latency the bench expects, and it makes the one-cycle pad delay observable at the ports.

// File: rtl/tone_div_out_pkg.sv
package tone_div_out_pkg;

   typedef enum logic [1:0] {
      BZ_PAIR   = 2'd0,
      BZ_SINGLE = 2'd1,
      BZ_OFF    = 2'd2
   } bz_mode_e;

   function automatic bz_mode_e bz_mode(input logic sel_a, input logic sel_b);
      if (sel_a)      return BZ_OFF;
      else if (sel_b) return BZ_SINGLE;
      else            return BZ_PAIR;
   endfunction

endpackage

// File: rtl/reload_timer.sv
module reload_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] preload,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   assign ovf = run && (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || ovf)  cnt <= preload;
      else                   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/div_toggle.sv
module div_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf,
   output logic div_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   div_q <= 1'b0;
      else if (ovf) div_q <= ~div_q;
   end
endmodule

// File: rtl/pad_mux.sv
module pad_mux
   import tone_div_out_pkg::*;
(
   input  logic tone,
   input  logic div_q,
   input  logic dat_bz_a,
   input  logic dat_bz_b,
   input  logic dat_div,
   output logic nx_bz_a,
   output logic nx_bz_b,
   output logic nx_div
);
   bz_mode_e mode;

   assign mode = bz_mode(dat_bz_a, dat_bz_b);

   always_comb begin
      nx_bz_a = 1'b0;
      nx_bz_b = 1'b0;
      unique case (mode)
         BZ_PAIR:   begin nx_bz_a = tone; nx_bz_b = ~tone; end
         BZ_SINGLE: begin nx_bz_a = tone; nx_bz_b = 1'b0;  end
         default:   begin nx_bz_a = 1'b0; nx_bz_b = 1'b0;  end
      endcase
      nx_div = dat_div ? 1'b0 : div_q;
   end
endmodule

// File: rtl/tone_div_out.sv
module tone_div_out #(
   parameter int CNT_W    = 8,
   parameter int REG_PADS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] preload,
   input  logic             tone,
   input  logic             dat_bz_a,
   input  logic             dat_bz_b,
   input  logic             dat_div,
   output logic             pad_bz_a,
   output logic             pad_bz_b,
   output logic             pad_div
);
   generate
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_cnt_w
         $error("tone_div_out: CNT_W must lie in 2..24");
      end
      if (REG_PADS != 0 && REG_PADS != 1) begin : g_bad_reg
         $error("tone_div_out: REG_PADS must be 0 or 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             ovf;
   logic             div_q;
   logic             nx_bz_a, nx_bz_b, nx_div;

   reload_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .preload(preload),
      .cnt(cnt), .ovf(ovf)
   );

   div_toggle u_div (
      .clk(clk), .rst_n(rst_n), .ovf(ovf), .div_q(div_q)
   );

   pad_mux u_mux (
      .tone(tone), .div_q(div_q),
      .dat_bz_a(dat_bz_a), .dat_bz_b(dat_bz_b), .dat_div(dat_div),
      .nx_bz_a(nx_bz_a), .nx_bz_b(nx_bz_b), .nx_div(nx_div)
   );

   generate
      if (REG_PADS == 1) begin : g_reg_pads
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pad_bz_a <= 1'b0;
               pad_bz_b <= 1'b0;
               pad_div  <= 1'b0;
            end else begin
               pad_bz_a <= nx_bz_a;
               pad_bz_b <= nx_bz_b;
               pad_div  <= nx_div;
            end
         end
      end else begin : g_comb_pads
         assign pad_bz_a = nx_bz_a;
         assign pad_bz_b = nx_bz_b;
         assign pad_div  = nx_div;
      end
   endgenerate
endmodule

// File: rtl/tone_div_out_chk.sv
module tone_div_out_chk #(
   parameter int CNT_W    = 8,
   parameter int REG_PADS = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic [CNT_W-1:0] preload,
   input logic [CNT_W-1:0] cnt,
   input logic             ovf,
   input logic             div_q,
   input logic             dat_div,
   input logic             dat_bz_a,
   input logic             pad_div,
   input logic             pad_bz_a,
   input logic             pad_bz_b
);
   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ovf) |=> (cnt == $past(cnt) + 1'b1));

   p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (cnt == $past(preload)));

   p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (div_q != $past(div_q)));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf |=> $stable(div_q));

   generate
      if (REG_PADS == 1) begin : g_chk_reg
         p_div_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
            dat_div |=> !pad_div);
         p_bz_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
            dat_bz_a |=> (!pad_bz_a && !pad_bz_b));
      end else begin : g_chk_comb
         p_div_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
            dat_div |-> !pad_div);
         p_bz_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
            dat_bz_a |-> (!pad_bz_a && !pad_bz_b));
      end
   endgenerate
endmodule

bind tone_div_out tone_div_out_chk #(.CNT_W(CNT_W), .REG_PADS(REG_PADS)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .preload(preload), .cnt(cnt),
   .ovf(ovf), .div_q(div_q), .dat_div(dat_div), .dat_bz_a(dat_bz_a),
   .pad_div(pad_div), .pad_bz_a(pad_bz_a), .pad_bz_b(pad_bz_b)
);

// File: tb/tone_div_out_tb_top.sv
`timescale 1ns/1ps
module tone_div_out_tb_top;
   localparam int CNT_W    = 8;
   localparam int REG_PADS = 1;
   localparam int SPAN     = 1 << CNT_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             run = 1'b0;
   logic [CNT_W-1:0] preload = '0;
   logic             tone = 1'b0;
   logic             dat_bz_a = 1'b0, dat_bz_b = 1'b0, dat_div = 1'b0;
   logic             pad_bz_a, pad_bz_b, pad_div;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   tone_div_out #(.CNT_W(CNT_W), .REG_PADS(REG_PADS)) dut_i (
      .clk(clk), .rst_n(rst_n), .run(run), .preload(preload), .tone(tone),
      .dat_bz_a(dat_bz_a), .dat_bz_b(dat_bz_b), .dat_div(dat_div),
      .pad_bz_a(pad_bz_a), .pad_bz_b(pad_bz_b), .pad_div(pad_div)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic measure_half(output int cyc);
      logic prev;
      prev = pad_div;
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (pad_div == prev && cyc < 4 * SPAN);
   endtask

   task automatic t_reset();
      check(pad_div == 1'b0, "R10", "pad_div in reset", pad_div, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(pad_div == 1'b0, "R10", "pad_div after reset", pad_div, 0);
   endtask

   task automatic t_buzzer();
      for (int m = 0; m < 4; m++) begin
         for (int t = 0; t < 2; t++) begin
            logic ea, eb;
            dat_bz_a = m[1];
            dat_bz_b = m[0];
            tone = t[0];
            ea = m[1] ? 1'b0 : t[0];
            eb = m[1] ? 1'b0 : (m[0] ? 1'b0 : ~t[0]);
            @(negedge clk);
            check(pad_bz_a == ea, m[1] ? "R8" : (m[0] ? "R7" : "R6"),
                  "pad_bz_a", pad_bz_a, ea);
            check(pad_bz_b == eb, m[1] ? "R8" : (m[0] ? "R7" : "R6"),
                  "pad_bz_b", pad_bz_b, eb);
         end
      end
      dat_bz_a = 1'b0; dat_bz_b = 1'b0; tone = 1'b0;
      @(negedge clk);
      tone = 1'b1;
      #1;
      check(pad_bz_a == 1'b0, "R9", "pad_bz_a before edge", pad_bz_a, 0);
      @(negedge clk);
      check(pad_bz_a == 1'b1, "R9", "pad_bz_a after edge", pad_bz_a, 1);
   endtask

   task automatic t_period(input int n);
      int c;
      run = 1'b0; dat_div = 1'b0;
      preload = CNT_W'(n);
      repeat (2) @(negedge clk);
      run = 1'b1;
      measure_half(c);
      check(c == SPAN - n + REG_PADS, "R1", $sformatf("first toggle N=%0d", n), c, SPAN - n + REG_PADS);
      for (int k = 0; k < 2; k++) begin
         measure_half(c);
         check(c == SPAN - n, "R3", $sformatf("half period N=%0d", n), c, SPAN - n);
      end
   endtask

   task automatic t_stop_hold();
      logic held;
      run = 1'b0;
      @(negedge clk);
      held = pad_div;
      repeat (20) @(negedge clk);
      check(pad_div == held, "R5", "pad_div held while stopped", pad_div, held);
   endtask

   task automatic t_preload_mid();
      int c;
      t_period(200);
      repeat (10) @(negedge clk);
      preload = CNT_W'(250);
      measure_half(c);
      check(c == 46, "R2", "half period in progress", c, 46);
      measure_half(c);
      check(c == 6, "R2", "half period after reload", c, 6);
   endtask

   task automatic t_div_force();
      int bad;
      bad = 0;
      preload = CNT_W'(250);
      run = 1'b1;
      dat_div = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (pad_div != 1'b0) bad++;
      end
      check(bad == 0, "R4", "pad_div nonzero samples while forced", bad, 0);
      dat_div = 1'b0;
      run = 1'b0;
   endtask

   initial begin
      t_reset();
      t_buzzer();
      t_period(250);
      t_stop_hold();
      t_period(0);
      t_period(255);
      t_stop_hold();
      t_preload_mid();
      t_div_force();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule